// File: doc/BRIEF.md
# TMDS Channel Encoder with Period Sequencing

This block produces the 10-bit symbol stream for one data lane of a TMDS-based video source link. On every pixel clock it emits exactly one symbol. What kind of symbol it emits depends on the link period the block is in: control, data island or video.

- In video periods, 8-bit pixel values are transition-minimized and DC-balanced against a running disparity.
- In data island periods, 4-bit packet nibbles are mapped through the TERC4 table.
- In control periods, the 2 control bits select one of four fixed control symbols.

The block also runs the period sequencing itself. Upstream logic only raises a video request or a data island request. The block then inserts the leading and trailing guard-band symbols. It also makes sure every pair of non-control periods is separated by control symbols, and it holds a request back until that has happened.

The parameter `CHAN` selects which lane (0, 1 or 2) the instance drives. The lane changes which guard-band symbols are used. Serialization, the clock lane and packet assembly are done elsewhere.

Top module: `tmds_channel_enc`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls with `ctl_i`=0 and no request, `tmds_o` is 1101010100 (bit 9 written first). The sequencer starts in the control period with zero disparity.
- R2: In a video period the pixel is encoded as follows.
  - Let n1 be the number of ones in `pix_i`. XNOR chaining is used when n1>4, or when n1==4 and bit 0 is 0; XOR chaining is used otherwise. Bit 8 of the intermediate word is 1 for XOR and 0 for XNOR.
  - The output and the signed disparity D are chosen by the usual three cases:
    - If D==0 or the word is balanced, bit 9 = not bit 8, and the data bits are inverted only when bit 8 is 0.
    - If D and the word imbalance share a sign, the data bits are inverted and bit 9 = 1.
    - Otherwise the data bits pass as they are and bit 9 = 0.
  - D is updated to match the case taken.
- R3: In a control period, `ctl_i` values 0, 1, 2 and 3 produce 1101010100, 0010101011, 0101010100 and 1010101011 respectively.
- R4: In a data island period, `pkt_i` values 0 through 15 produce the following symbols:
  - 0 to 3: 1010011100, 1001100011, 1011100100, 1011100010
  - 4 to 7: 0101110001, 0100011110, 0110001110, 0100111100
  - 8 to 11: 1011001100, 0100111001, 0110011100, 1011000110
  - 12 to 15: 1010001110, 1001110001, 0101100011, 1011000011
- R5: Every video period is immediately preceded by exactly GUARD_LEN (default 2) guard symbols. The guard symbol is 1011001100 on lanes 0 and 2, and 0100110011 on lane 1.
- R6: Every data island period is preceded and followed by GUARD_LEN guard symbols. On lane 0 the guard symbol is the R4 symbol of nibble {1,1,`ctl_i`[1],`ctl_i`[0]}; on the other lanes it is 0100110011.
- R7: A non-control period is only left toward control symbols. A new guard sequence can only start after at least CTL_MIN (default 1) control symbols have been emitted. A video request raised during an island therefore waits through the trailing guards and one control symbol.
- R8: The disparity is zero at the first pixel of every video period, because it is cleared in all non-video cycles.
- R9: When both requests are high in a control cycle that is allowed to leave, the video period is chosen.
- R10: The symbol for the inputs present at a clock edge appears on `tmds_o` right after that edge (one register of latency).
- R11: A video period lasts as long as `vid_req_i` stays high. The cycle in which it is sampled low still encodes a pixel, and the next symbol is a control symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (character) clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_req_i | input | 1 | Request/hold a video period |
| isl_req_i | input | 1 | Request/hold a data island period |
| ctl_i | input | 2 | Control bits for control symbols and lane-0 island guards |
| pkt_i | input | 4 | Packet nibble for island symbols |
| pix_i | input | 8 | Pixel component for video symbols |
| tmds_o | output | 10 | Registered 10-bit channel symbol |

## Verification
The assertions put no constraint on the request inputs: any toggling pattern is legal, and the sequencer has to absorb it. They do rely on the `ctl_i`, `pkt_i` and `pix_i` inputs being driven to known values every cycle, so that the symbol sets checked after control and island cycles are well defined. The stimulus drives every data input on every cycle, including cycles whose period ignores it. It toggles the two requests with random run lengths so that they overlap, drop during guards and rise during islands.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int SYM_W = 10;
  localparam int PIX_W = 8;
  localparam int NIB_W = 4;
  localparam int CTL_W = 2;
  localparam int DSP_W = 6;

  typedef enum logic [2:0] {
    PH_CTL   = 3'd0,
    PH_VPRE  = 3'd1,
    PH_VID   = 3'd2,
    PH_IPRE  = 3'd3,
    PH_ISL   = 3'd4,
    PH_IPOST = 3'd5
  } phase_e;

  localparam logic [SYM_W-1:0] GUARD_SYM_A = 10'b1011001100;
  localparam logic [SYM_W-1:0] GUARD_SYM_B = 10'b0100110011;

  function automatic logic [SYM_W-1:0] ctl_symbol(input logic [CTL_W-1:0] c);
    logic [SYM_W-1:0] s;
    unique case (c)
      2'd0: s = 10'b1101010100;
      2'd1: s = 10'b0010101011;
      2'd2: s = 10'b0101010100;
      default: s = 10'b1010101011;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tmds_terc4_map.sv
module tmds_terc4_map
  import tmds_enc_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SYM_W-1:0] sym_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: sym_o = 10'b1010011100;
      4'h1: sym_o = 10'b1001100011;
      4'h2: sym_o = 10'b1011100100;
      4'h3: sym_o = 10'b1011100010;
      4'h4: sym_o = 10'b0101110001;
      4'h5: sym_o = 10'b0100011110;
      4'h6: sym_o = 10'b0110001110;
      4'h7: sym_o = 10'b0100111100;
      4'h8: sym_o = 10'b1011001100;
      4'h9: sym_o = 10'b0100111001;
      4'hA: sym_o = 10'b0110011100;
      4'hB: sym_o = 10'b1011000110;
      4'hC: sym_o = 10'b1010001110;
      4'hD: sym_o = 10'b1001110001;
      4'hE: sym_o = 10'b0101100011;
      default: sym_o = 10'b1011000011;
    endcase
  end
endmodule

// File: rtl/tmds_tm_enc.sv
// Transition-minimized, DC-balanced pixel coder with its disparity register.
module tmds_tm_enc #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic [DW-1:0]        d,
  output logic [DW+1:0]        sym,
  output logic signed [CW-1:0] disp
);
  localparam int HALF = DW / 2;
  localparam int NW   = $clog2(DW + 1);
  localparam logic signed [CW-1:0] TWO = CW'(2);

  logic [NW-1:0]        n1_d, n1_q;
  logic                 use_xnor;
  logic [DW:0]          qm;
  logic signed [CW-1:0] bal, disp_d, disp_q;

  always_comb begin
    n1_d = '0;
    for (int i = 0; i < DW; i++) n1_d = n1_d + NW'(d[i]);
    use_xnor = (int'(n1_d) > HALF) || ((int'(n1_d) == HALF) && !d[0]);
    qm[0] = d[0];
    for (int i = 1; i < DW; i++) qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[DW] = ~use_xnor;
    n1_q = '0;
    for (int i = 0; i < DW; i++) n1_q = n1_q + NW'(qm[i]);
    bal = CW'(2 * int'(n1_q) - DW);
  end

  always_comb begin
    if (disp_q == '0 || bal == '0) begin
      sym    = {~qm[DW], qm[DW], (qm[DW] ? qm[DW-1:0] : ~qm[DW-1:0])};
      disp_d = qm[DW] ? (disp_q + bal) : (disp_q - bal);
    end else if ((disp_q > 0 && bal > 0) || (disp_q < 0 && bal < 0)) begin
      sym    = {1'b1, qm[DW], ~qm[DW-1:0]};
      disp_d = disp_q - bal + (qm[DW] ? TWO : '0);
    end else begin
      sym    = {1'b0, qm[DW], qm[DW-1:0]};
      disp_d = disp_q + bal - (qm[DW] ? '0 : TWO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) disp_q <= '0;
    else if (en)    disp_q <= disp_d;
  end

  assign disp = disp_q;
endmodule

// File: rtl/tmds_period_seq.sv
// Period state machine: guard insertion and control-gap enforcement.
module tmds_period_seq
  import tmds_enc_pkg::*;
#(
  parameter int GUARD_LEN = 2,
  parameter int CTL_MIN   = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   vid_req,
  input  logic   isl_req,
  output phase_e phase_o
);
  localparam int GW = (GUARD_LEN > 1) ? $clog2(GUARD_LEN) : 1;
  localparam int CW = $clog2(CTL_MIN + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GUARD_LEN - 1);
  localparam logic [CW-1:0] C_MAX  = CW'(CTL_MIN);
  localparam logic [CW-1:0] C_GATE = CW'(CTL_MIN - 1);

  phase_e        ph_q, ph_d;
  logic [GW-1:0] g_q, g_d;
  logic [CW-1:0] c_q, c_d;
  logic          may_leave, in_guard, g_last;

  assign may_leave = (c_q >= C_GATE);
  assign in_guard  = (ph_q == PH_VPRE) || (ph_q == PH_IPRE) || (ph_q == PH_IPOST);
  assign g_last    = (g_q == G_LAST);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_CTL: begin
        if (may_leave && vid_req)      ph_d = PH_VPRE;
        else if (may_leave && isl_req) ph_d = PH_IPRE;
      end
      PH_VPRE:  if (g_last) ph_d = PH_VID;
      PH_VID:   if (!vid_req) ph_d = PH_CTL;
      PH_IPRE:  if (g_last) ph_d = PH_ISL;
      PH_ISL:   if (!isl_req) ph_d = PH_IPOST;
      PH_IPOST: if (g_last) ph_d = PH_CTL;
      default:  ph_d = PH_CTL;
    endcase
    g_d = (in_guard && !g_last) ? g_q + GW'(1) : '0;
    if (ph_q == PH_CTL) c_d = (c_q == C_MAX) ? c_q : c_q + CW'(1);
    else                c_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_CTL;
      g_q  <= '0;
      c_q  <= '0;
    end else begin
      ph_q <= ph_d;
      g_q  <= g_d;
      c_q  <= c_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/tmds_channel_enc.sv
module tmds_channel_enc
  import tmds_enc_pkg::*;
#(
  parameter int CHAN      = 0,
  parameter int GUARD_LEN = 2,
  parameter int CTL_MIN   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vid_req_i,
  input  logic             isl_req_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [NIB_W-1:0] pkt_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [SYM_W-1:0] tmds_o
);
  phase_e               phase_w;
  logic [SYM_W-1:0]     vid_sym, terc_sym, vguard, iguard, sym_d, sym_q;
  logic [NIB_W-1:0]     terc_in;
  logic signed [DSP_W-1:0] disp_w;

  tmds_period_seq #(.GUARD_LEN(GUARD_LEN), .CTL_MIN(CTL_MIN)) u_seq (
    .clk(clk), .rst(rst), .vid_req(vid_req_i), .isl_req(isl_req_i), .phase_o(phase_w)
  );

  tmds_tm_enc #(.DW(PIX_W), .CW(DSP_W)) u_venc (
    .clk(clk), .rst(rst),
    .en(phase_w == PH_VID), .clr(phase_w != PH_VID),
    .d(pix_i), .sym(vid_sym), .disp(disp_w)
  );

  assign terc_in = (phase_w == PH_ISL) ? pkt_i : {2'b11, ctl_i};

  tmds_terc4_map u_terc (.nib_i(terc_in), .sym_o(terc_sym));

  generate
    if (CHAN == 1) begin : g_vg_b
      assign vguard = GUARD_SYM_B;
    end else begin : g_vg_a
      assign vguard = GUARD_SYM_A;
    end
    if (CHAN == 0) begin : g_ig_terc
      assign iguard = terc_sym;
    end else begin : g_ig_fixed
      assign iguard = GUARD_SYM_B;
    end
  endgenerate

  always_comb begin
    unique case (phase_w)
      PH_VPRE:           sym_d = vguard;
      PH_VID:            sym_d = vid_sym;
      PH_IPRE, PH_IPOST: sym_d = iguard;
      PH_ISL:            sym_d = terc_sym;
      default:           sym_d = ctl_symbol(ctl_i);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sym_q <= ctl_symbol(2'd0);
    else     sym_q <= sym_d;
  end

  assign tmds_o = sym_q;
endmodule

// File: rtl/tmds_channel_chk.sv
module tmds_channel_chk
  import tmds_enc_pkg::*;
#(
  parameter int CHAN = 0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    vid_req,
  input logic                    isl_req,
  input phase_e                  phase,
  input logic signed [DSP_W-1:0] disp,
  input logic [SYM_W-1:0]        tmds
);
  localparam logic [SYM_W-1:0] VG = (CHAN == 1) ? GUARD_SYM_B : GUARD_SYM_A;

  // R3: a control cycle yields one of the four control symbols
  a_r3_ctl_symbol: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CTL) |=> (tmds inside {10'b1101010100, 10'b0010101011,
                                        10'b0101010100, 10'b1010101011}));

  // R5: the two symbols before the first video pixel are video guards
  a_r5_guard_before_video: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VID && $past(phase) != PH_VID) |-> (tmds == VG && $past(tmds) == VG));

  // R7: video exits only toward control
  a_r7_video_exit: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VID) |=> (phase inside {PH_VID, PH_CTL}));

  // R7: island exits only toward trailing guard
  a_r7_island_exit: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ISL) |=> (phase inside {PH_ISL, PH_IPOST}));

  // R7: leading guards are entered only from control
  a_r7_vpre_from_ctl: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VPRE && $past(phase) != PH_VPRE) |-> ($past(phase) == PH_CTL));

  a_r7_ipre_from_ctl: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IPRE && $past(phase) != PH_IPRE) |-> ($past(phase) == PH_CTL));

  // R8: disparity is cleared by any non-video cycle
  a_r8_disp_clear: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_VID) |=> (disp == '0));

  // R2: running disparity moves in even steps
  a_r2_disp_even: assert property (@(posedge clk) disable iff (rst)
    (disp[0] == 1'b0));

  // R9: a simultaneous request never opens an island
  a_r9_video_first: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CTL && vid_req && isl_req) |=> (phase != PH_IPRE));
endmodule

bind tmds_channel_enc tmds_channel_chk #(.CHAN(CHAN)) u_chk (
  .clk(clk), .rst(rst), .vid_req(vid_req_i), .isl_req(isl_req_i),
  .phase(phase_w), .disp(disp_w), .tmds(tmds_o)
);

// File: tb/tb_tmds_channel_enc.sv
`timescale 1ns/1ps
module tb_tmds_channel_enc;
  localparam int GUARD_LEN = 2;
  localparam int CTL_MIN   = 1;
  localparam int S_CTL = 0, S_VPRE = 1, S_VID = 2, S_IPRE = 3, S_ISL = 4, S_IPOST = 5;
  localparam logic [9:0] VG0 = 10'b1011001100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vid_req_i = 1'b0, isl_req_i = 1'b0;
  logic [1:0] ctl_i = '0;
  logic [3:0] pkt_i = '0;
  logic [7:0] pix_i = '0;
  logic [9:0] tmds_o;

  int n_chk = 0, n_bad = 0;
  int ms = S_CTL, mg = 0, mc = 0, mdisp = 0, mprev = S_CTL;
  logic [9:0] last_out;
  bit done = 0;

  always #2 clk = ~clk;

  tmds_channel_enc #(.CHAN(0), .GUARD_LEN(GUARD_LEN), .CTL_MIN(CTL_MIN)) dut (
    .clk(clk), .rst(rst), .vid_req_i(vid_req_i), .isl_req_i(isl_req_i),
    .ctl_i(ctl_i), .pkt_i(pkt_i), .pix_i(pix_i), .tmds_o(tmds_o)
  );

  function automatic logic [9:0] ref_ctl(input logic [1:0] c);
    case (c)
      2'd0: return 10'b1101010100;
      2'd1: return 10'b0010101011;
      2'd2: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] ref_terc(input logic [3:0] n);
    case (n)
      0: return 10'b1010011100;  1: return 10'b1001100011;
      2: return 10'b1011100100;  3: return 10'b1011100010;
      4: return 10'b0101110001;  5: return 10'b0100011110;
      6: return 10'b0110001110;  7: return 10'b0100111100;
      8: return 10'b1011001100;  9: return 10'b0100111001;
      10: return 10'b0110011100; 11: return 10'b1011000110;
      12: return 10'b1010001110; 13: return 10'b1001110001;
      14: return 10'b0101100011; default: return 10'b1011000011;
    endcase
  endfunction

  function automatic logic [9:0] ref_video(input logic [7:0] d, inout int disp);
    int ones = 0, o1 = 0, o0;
    bit inv;
    logic [8:0] m;
    logic [9:0] r;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    inv = (ones > 4) || (ones == 4 && d[0] == 1'b0);
    m[0] = d[0];
    for (int i = 1; i < 8; i++) m[i] = m[i-1] ^ d[i] ^ inv;
    m[8] = !inv;
    for (int i = 0; i < 8; i++) o1 += int'(m[i]);
    o0 = 8 - o1;
    if (disp == 0 || o1 == o0) begin
      r = {!m[8], m[8], (m[8] ? m[7:0] : ~m[7:0])};
      disp = disp + (m[8] ? (o1 - o0) : (o0 - o1));
    end else if ((disp > 0 && o1 > o0) || (disp < 0 && o0 > o1)) begin
      r = {1'b1, m[8], ~m[7:0]};
      disp = disp + 2 * int'(m[8]) + o0 - o1;
    end else begin
      r = {1'b0, m[8], m[7:0]};
      disp = disp - 2 * int'(!m[8]) + o1 - o0;
    end
    return r;
  endfunction

  task automatic check(input logic [9:0] got, input logic [9:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: tmds_o=%b expected %b", req, got, exp);
    end
  endtask

  // One pixel clock: drive at negedge, predict, sample 1 ns after posedge.
  task automatic step(input bit v, input bit i, input logic [1:0] c,
                      input logic [3:0] p, input logic [7:0] x);
    logic [9:0] exp;
    string tag;
    int nms;
    vid_req_i = v; isl_req_i = i; ctl_i = c; pkt_i = p; pix_i = x;
    nms = ms;
    case (ms)
      S_CTL: begin
        exp = ref_ctl(c); tag = "R3";
        if (mc + 1 >= CTL_MIN && v)      nms = S_VPRE;
        else if (mc + 1 >= CTL_MIN && i) nms = S_IPRE;
      end
      S_VPRE: begin
        exp = VG0; tag = "R5";
        if (mg == GUARD_LEN - 1) nms = S_VID;
      end
      S_VID: begin
        tag = (mprev != S_VID) ? "R8" : "R2";
        exp = ref_video(x, mdisp);
        if (!v) nms = S_CTL;
      end
      S_IPRE: begin
        exp = ref_terc({2'b11, c}); tag = "R6";
        if (mg == GUARD_LEN - 1) nms = S_ISL;
      end
      S_ISL: begin
        exp = ref_terc(p); tag = "R4";
        if (!i) nms = S_IPOST;
      end
      default: begin
        exp = ref_terc({2'b11, c}); tag = "R6";
        if (mg == GUARD_LEN - 1) nms = S_CTL;
      end
    endcase
    if (ms == S_VPRE || ms == S_IPRE || ms == S_IPOST)
      mg = (mg == GUARD_LEN - 1) ? 0 : mg + 1;
    else
      mg = 0;
    mc = (ms == S_CTL) ? ((mc + 1 > CTL_MIN) ? CTL_MIN : mc + 1) : 0;
    if (ms != S_VID) mdisp = 0;
    mprev = ms;
    ms = nms;
    @(posedge clk); #1;
    check(tmds_o, exp, tag);
    last_out = tmds_o;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    bit v, i;
    void'($urandom(32'd20240611));
    // R1: reset symbol
    repeat (4) @(posedge clk);
    #1 check(tmds_o, 10'b1101010100, "R1");
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 2'd0, 4'h0, 8'h00);
    check(last_out, 10'b1101010100, "R1");

    // R3 / R10: control codes, one-cycle latency
    for (int k = 0; k < 4; k++) step(0, 0, 2'(k), 4'h0, 8'h00);
    step(0, 0, 2'd1, 4'h0, 8'h00);
    check(last_out, 10'b0010101011, "R10");
    step(0, 0, 2'd3, 4'h0, 8'h00);
    check(last_out, 10'b1010101011, "R10");

    // R2 / R5 / R11: directed video burst
    step(1, 0, 2'd0, 4'h0, 8'h00);
    step(1, 0, 2'd0, 4'h0, 8'h00);
    step(1, 0, 2'd0, 4'h0, 8'h00);
    foreach (pix_list[k]) step(1, 0, 2'd0, 4'h0, pix_list[k]);
    step(0, 0, 2'd2, 4'h0, 8'h3C);
    step(0, 0, 2'd2, 4'h0, 8'h00);
    check(last_out, 10'b0101010100, "R11");

    // R8: re-enter video with the same pixels
    for (int k = 0; k < 6; k++) step(1, 0, 2'd0, 4'h0, 8'hF3);
    step(0, 0, 2'd0, 4'h0, 8'h00);

    // R4 / R6: island carrying every nibble
    step(0, 1, 2'd1, 4'h0, 8'h00);
    step(0, 1, 2'd1, 4'h0, 8'h00);
    step(0, 1, 2'd2, 4'h0, 8'h00);
    for (int k = 0; k < 16; k++) step(0, (k != 15), 2'd3, 4'(k), 8'h00);
    step(0, 0, 2'd0, 4'h0, 8'h00);
    step(0, 0, 2'd1, 4'h0, 8'h00);
    step(0, 0, 2'd0, 4'h0, 8'h00);

    // R9: both requests together pick video
    step(1, 1, 2'd0, 4'h5, 8'h10);
    step(1, 1, 2'd0, 4'h5, 8'h10);
    check(last_out, VG0, "R9");
    step(1, 1, 2'd0, 4'h5, 8'h10);
    step(0, 0, 2'd0, 4'h5, 8'h10);
    step(0, 0, 2'd0, 4'h0, 8'h00);

    // R7: video request raised during an island waits
    step(0, 1, 2'd2, 4'h1, 8'h00);
    step(0, 1, 2'd2, 4'h1, 8'h00);
    step(0, 1, 2'd2, 4'h1, 8'h00);
    step(1, 1, 2'd2, 4'h2, 8'h00);
    step(1, 0, 2'd2, 4'h3, 8'h00);
    step(1, 0, 2'd2, 4'h3, 8'h00);
    step(1, 0, 2'd2, 4'h3, 8'h00);
    step(1, 0, 2'd2, 4'h3, 8'h00);
    check(last_out, 10'b0101010100, "R7");
    step(1, 0, 2'd2, 4'h3, 8'h00);
    check(last_out, VG0, "R7");
    step(1, 0, 2'd2, 4'h3, 8'h00);
    step(0, 0, 2'd2, 4'h3, 8'h77);
    step(0, 0, 2'd0, 4'h0, 8'h00);

    // random traffic
    v = 0; i = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 5) == 0) v = !v;
      if ($urandom_range(0, 6) == 0) i = !i;
      step(v, i, 2'($urandom), 4'($urandom), 8'($urandom));
    end
    finish_run();
  end

  logic [7:0] pix_list [8] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hAA, 8'h55, 8'h01, 8'h80};
endmodule